// File: doc/BRIEF.md
# Random-Replacement Write-Back Data Cache with Uncached Bypass

This block is a data cache placed between a 32-bit processor port and an external memory port. It holds 16 KB, arranged as 4 ways of 256 sets. Each line is 16 bytes (four words) and sits on a 16-byte boundary. A lookup miss brings in the whole line as a four-word burst. When every way of the set is valid, the victim is picked pseudo-randomly, not by age. Stores hit or allocate, and they mark the line dirty. A dirty victim is written out as a four-word burst before its replacement is fetched.

The top four address bits select one of 16 memory regions. A parameter mask marks each region as cached or uncached. An uncached access skips the cache completely. It becomes one single-word memory transfer that carries the processor's byte strobes, so a part-word store needs no read-modify-write. Such an access never changes a tag, a valid bit, a dirty bit or a data word.

The processor holds its request until it sees a one-cycle ready pulse. The memory side is a request/ready handshake with one beat per word.

Top module: `rrc_cache`

## Requirements
- R1: After reset, `cpu_ready_o` and `mem_req_o` are low and every line is invalid, so the first cached access to any address misses.
- R2: The set index is address bits [11:4] and the tag is bits [31:12]. Four lines with the same set index and different tags can all be resident at once, and re-reading them causes no memory traffic.
- R3: On a hit, `cpu_ready_o` rises two clock edges after the request is first sampled, with no memory transfer, and a read returns the stored word.
- R4: A read miss fetches the line as four read beats with `mem_burst_o`=1. The beat addresses are the line base plus 0, 4, 8 and 12, in that order.
- R5: A store changes only the bytes whose `cpu_be_i` bit is set (bit n covers data bits 8n+7:8n). A store hit makes no memory transfer. A store miss allocates the line with a refill and writes nothing to memory at that point.
- R6: While a set has an invalid way, a miss fills an invalid way and evicts nothing.
- R7: In a full set, the victim comes from a non-zero 16-bit LFSR that advances on every miss. Over a run of misses the eviction order is not oldest-first, and each evicted line was resident.
- R8: A dirty victim goes out as four write beats (`mem_we_o`=1, `mem_be_o`=4'b1111, `mem_burst_o`=1) at its own line addresses in ascending order. The refill reads start only after these four beats. Data written back reads back correctly later.
- R9: An address whose region bit in `UNC_MAP` is set (default: region 4'hF) makes exactly one memory beat with `mem_burst_o`=0, `mem_be_o`=`cpu_be_i` and the processor's address. It allocates nothing and leaves cached lines resident.
- R10: While `mem_req_o` is high and `mem_ready_i` is low, the request and address hold stable into the next cycle.
- R11: `cpu_ready_o` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request, held until ready |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_addr_i | input | 32 | Byte address |
| cpu_be_i | input | 4 | Byte enables of the store |
| cpu_wdata_i | input | 32 | Store data |
| cpu_ready_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | 32 | Load data, valid with ready |
| mem_req_o | output | 1 | Memory beat request |
| mem_we_o | output | 1 | 1 = write beat |
| mem_burst_o | output | 1 | Beat belongs to a four-word line burst |
| mem_addr_o | output | 32 | Beat address |
| mem_be_o | output | 4 | Byte strobes of the beat |
| mem_wdata_o | output | 32 | Write data of the beat |
| mem_ready_i | input | 1 | Beat complete |
| mem_rdata_i | input | 32 | Read data, valid with ready |

## Verification
The hardest case to reach from the ports is a random eviction out of a full set. The victim's way is never visible, so the bench fills one set with four dirty lines and then stores to twelve more tags in that same set. Each store forces a write-back, and the write-back address names the line that was evicted. The bench keeps an age-ordered list of the resident tags and checks each evicted tag against it. It then checks that at least one eviction was not the oldest line, and that every evicted line reads back from memory with its stored value.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
  localparam int WORD_W = 32;
  localparam int BE_W   = WORD_W / 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOK, ST_WB, ST_FILL, ST_ALLOC, ST_UNC, ST_RESP
  } state_e;

  function automatic logic [WORD_W-1:0] merge_word(input logic [WORD_W-1:0] old_w,
                                                   input logic [WORD_W-1:0] new_w,
                                                   input logic [BE_W-1:0]   be);
    logic [WORD_W-1:0] res;
    for (int b = 0; b < BE_W; b++)
      res[8*b +: 8] = be[b] ? new_w[8*b +: 8] : old_w[8*b +: 8];
    return res;
  endfunction
endpackage

// File: rtl/rrc_lfsr.sv
module rrc_lfsr #(
  parameter int          W     = 16,
  parameter int          OUT_W = 2,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [OUT_W-1:0] rnd_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= SEED;
    else if (step_i) q <= (q >> 1) ^ (q[0] ? TAPS : '0);
  end

  assign rnd_o = q[OUT_W-1:0];

  AST_LFSR_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q != '0); // R7
  AST_LFSR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(q)); // R7
endmodule

// File: rtl/rrc_victim.sv
module rrc_victim #(
  parameter int WAYS  = 4,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WAYS-1:0]  valid_i,
  input  logic [WAY_W-1:0] rnd_i,
  output logic [WAY_W-1:0] way_o
);
  logic found;

  // lowest invalid way first, random way only in a full set
  always_comb begin
    way_o = rnd_i;
    found = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!valid_i[w] && !found) begin
        way_o = WAY_W'(w);
        found = 1'b1;
      end
    end
  end

  AST_INVALID_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&valid_i) |-> !valid_i[way_o]); // R6
endmodule

// File: rtl/rrc_store.sv
module rrc_store #(
  parameter int SETS   = 256,
  parameter int WAYS   = 4,
  parameter int TAG_W  = 20,
  parameter int LINE_W = 128,
  parameter int IDX_W  = $clog2(SETS),
  parameter int WAY_W  = $clog2(WAYS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [IDX_W-1:0]            idx_i,
  input  logic                        we_i,
  input  logic [WAY_W-1:0]            way_i,
  input  logic [TAG_W-1:0]            tag_i,
  input  logic                        dirty_i,
  input  logic [LINE_W-1:0]           line_i,
  output logic [WAYS-1:0][TAG_W-1:0]  tag_o,
  output logic [WAYS-1:0]             valid_o,
  output logic [WAYS-1:0]             dirty_o,
  output logic [WAYS-1:0][LINE_W-1:0] line_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [LINE_W-1:0] line_q [SETS];
    logic [SETS-1:0]   valid_q, dirty_q;
    logic              sel;

    assign sel = we_i && (way_i == WAY_W'(w));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= '0;
        dirty_q <= '0;
      end else if (sel) begin
        valid_q[idx_i] <= 1'b1;
        dirty_q[idx_i] <= dirty_i;
      end
    end

    always_ff @(posedge clk_i) begin
      if (sel) begin
        tag_q[idx_i]  <= tag_i;
        line_q[idx_i] <= line_i;
      end
    end

    assign tag_o[w]   = tag_q[idx_i];
    assign line_o[w]  = line_q[idx_i];
    assign valid_o[w] = valid_q[idx_i];
    assign dirty_o[w] = dirty_q[idx_i];
  end

  AST_STORE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> valid_o[$past(way_i)] || (idx_i != $past(idx_i))); // R2
endmodule

// File: rtl/rrc_cache.sv
module rrc_cache
  import rrc_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          WAYS      = 4,
  parameter int          SETS      = 256,
  parameter int          WORDS     = 4,
  parameter logic [15:0] UNC_MAP   = 16'h8000,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [BE_W-1:0]   cpu_be_i,
  input  logic [WORD_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [WORD_W-1:0] cpu_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_burst_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BE_W-1:0]   mem_be_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [WORD_W-1:0] mem_rdata_i
);
  localparam int SEL_W  = $clog2(WORDS);
  localparam int OFF_W  = SEL_W + 2;
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int WAY_W  = $clog2(WAYS);
  localparam int LINE_W = WORDS * WORD_W;

  state_e state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [BE_W-1:0]   be_q;
  logic [WORD_W-1:0] wdata_q, rdata_q;
  logic [SEL_W-1:0]  beat_q;
  logic [WAY_W-1:0]  vic_q, vic_way, hit_way, rnd;
  logic [WORDS-1:0][WORD_W-1:0] fill_q;

  logic [WAYS-1:0][TAG_W-1:0]  tag_rd;
  logic [WAYS-1:0][LINE_W-1:0] line_rd;
  logic [WAYS-1:0]             valid_rd, dirty_rd, hit_vec;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [SEL_W-1:0]  wsel;
  logic              hit, unc_in, last_beat, miss_step;
  logic [LINE_W-1:0] cur_line, merged_line;
  logic [WORD_W-1:0] hit_word;

  logic              st_we, st_dirty;
  logic [WAY_W-1:0]  st_way;
  logic [LINE_W-1:0] st_line;

  assign idx       = addr_q[OFF_W +: IDX_W];
  assign tag       = addr_q[ADDR_W-1 -: TAG_W];
  assign wsel      = addr_q[OFF_W-1:2];
  assign unc_in    = UNC_MAP[cpu_addr_i[ADDR_W-1 -: 4]];
  assign last_beat = (beat_q == SEL_W'(WORDS-1));

  // tag compare
  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = valid_rd[w] && (tag_rd[w] == tag);
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end
  assign hit = |hit_vec;

  assign cur_line = line_rd[hit_way];
  assign hit_word = cur_line[int'(wsel)*WORD_W +: WORD_W];

  always_comb begin
    merged_line = cur_line;
    merged_line[int'(wsel)*WORD_W +: WORD_W] = merge_word(hit_word, wdata_q, be_q);
  end

  assign miss_step = (state_q == ST_LOOK) && !hit;

  rrc_lfsr #(.W(16), .OUT_W(WAY_W), .TAPS(16'hB400), .SEED(LFSR_SEED)) i_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (miss_step),
    .rnd_o  (rnd)
  );

  rrc_victim #(.WAYS(WAYS)) i_victim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_rd),
    .rnd_i   (rnd),
    .way_o   (vic_way)
  );

  // store write port: store hit or line allocation
  always_comb begin
    st_we    = 1'b0;
    st_way   = vic_q;
    st_dirty = 1'b0;
    st_line  = fill_q;
    if (state_q == ST_LOOK && hit && we_q) begin
      st_we    = 1'b1;
      st_way   = hit_way;
      st_dirty = 1'b1;
      st_line  = merged_line;
    end else if (state_q == ST_ALLOC) begin
      st_we = 1'b1;
    end
  end

  rrc_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .LINE_W(LINE_W)) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .idx_i   (idx),
    .we_i    (st_we),
    .way_i   (st_way),
    .tag_i   (tag),
    .dirty_i (st_dirty),
    .line_i  (st_line),
    .tag_o   (tag_rd),
    .valid_o (valid_rd),
    .dirty_o (dirty_rd),
    .line_o  (line_rd)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (cpu_req_i) state_d = unc_in ? ST_UNC : ST_LOOK;
      ST_LOOK:  if (hit) state_d = ST_RESP;
                else if (valid_rd[vic_way] && dirty_rd[vic_way]) state_d = ST_WB;
                else state_d = ST_FILL;
      ST_WB:    if (mem_ready_i && last_beat) state_d = ST_FILL;
      ST_FILL:  if (mem_ready_i && last_beat) state_d = ST_ALLOC;
      ST_ALLOC: state_d = ST_LOOK;
      ST_UNC:   if (mem_ready_i) state_d = ST_RESP;
      ST_RESP:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      we_q    <= 1'b0;
      be_q    <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      beat_q  <= '0;
      vic_q   <= '0;
      fill_q  <= '0;
    end else begin
      state_q <= state_d;
      unique case (state_q)
        ST_IDLE: if (cpu_req_i) begin
          addr_q  <= cpu_addr_i;
          we_q    <= cpu_we_i;
          be_q    <= cpu_be_i;
          wdata_q <= cpu_wdata_i;
        end
        ST_LOOK: begin
          if (hit) rdata_q <= hit_word;
          else begin
            vic_q  <= vic_way;
            beat_q <= '0;
          end
        end
        ST_WB:   if (mem_ready_i) beat_q <= beat_q + 1'b1;
        ST_FILL: if (mem_ready_i) begin
          fill_q[beat_q] <= mem_rdata_i;
          beat_q         <= beat_q + 1'b1;
        end
        ST_UNC:  if (mem_ready_i) rdata_q <= mem_rdata_i;
        default: ;
      endcase
    end
  end

  // memory side
  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_burst_o = 1'b0;
    mem_addr_o  = '0;
    mem_be_o    = '1;
    mem_wdata_o = '0;
    unique case (state_q)
      ST_WB: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_burst_o = 1'b1;
        mem_addr_o  = {tag_rd[vic_q], idx, beat_q, 2'b00};
        mem_wdata_o = line_rd[vic_q][int'(beat_q)*WORD_W +: WORD_W];
      end
      ST_FILL: begin
        mem_req_o   = 1'b1;
        mem_burst_o = 1'b1;
        mem_addr_o  = {tag, idx, beat_q, 2'b00};
      end
      ST_UNC: begin
        mem_req_o   = 1'b1;
        mem_we_o    = we_q;
        mem_addr_o  = addr_q;
        mem_be_o    = be_q;
        mem_wdata_o = wdata_q;
      end
      default: ;
    endcase
  end

  assign cpu_ready_o = (state_q == ST_RESP);
  assign cpu_rdata_o = rdata_q;

  AST_RDY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o |=> !cpu_ready_o); // R11
  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R10
  AST_HIT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_LOOK |-> $onehot0(hit_vec)); // R2
  AST_UNC_NO_ALLOC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_burst_o |-> !st_we); // R9
  AST_WB_BEFORE_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_burst_o && mem_ready_i && last_beat |=> mem_req_o && !mem_we_o); // R8
endmodule

// File: tb/test_rrc_cache.sv
module test_rrc_cache;
  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic        cpu_req, cpu_we, cpu_ready_o;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata_o;
  logic [3:0]  cpu_be;
  logic        mem_req_o, mem_we_o, mem_burst_o, mem_ready;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata;
  logic [3:0]  mem_be_o;

  rrc_cache i_rrc_cache (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_be_i(cpu_be),
    .cpu_wdata_i(cpu_wdata), .cpu_ready_o(cpu_ready_o), .cpu_rdata_o(cpu_rdata_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_burst_o(mem_burst_o),
    .mem_addr_o(mem_addr_o), .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o),
    .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata)
  );

  int n_chk = 0, n_bad = 0, unstable = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] init_word(input logic [29:0] k);
    return {k[15:0] ^ 16'h5A5A, ~k[15:0]};
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = be[b] ? n[8*b +: 8] : o[8*b +: 8];
    return r;
  endfunction

  // external memory model: one beat per two cycles
  logic [31:0] mem_arr [logic [29:0]];
  logic [29:0] mk;
  logic [31:0] mcur;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ready <= 1'b0;
      mem_rdata <= '0;
    end else if (mem_req_o && !mem_ready) begin
      mk   = mem_addr_o[31:2];
      mcur = mem_arr.exists(mk) ? mem_arr[mk] : init_word(mk);
      if (mem_we_o) begin
        mcur = merge(mcur, mem_wdata_o, mem_be_o);
        mem_arr[mk] = mcur;
      end
      mem_rdata <= mcur;
      mem_ready <= 1'b1;
    end else begin
      mem_ready <= 1'b0;
    end
  end

  // reference contents as the processor sees them
  logic [31:0] ref_mem [logic [29:0]];
  function automatic logic [31:0] ref_read(input logic [31:0] a);
    return ref_mem.exists(a[31:2]) ? ref_mem[a[31:2]] : init_word(a[31:2]);
  endfunction

  typedef struct {bit rd; logic [31:0] data; string req;} exp_t;
  exp_t exp_q[$];
  logic [31:0] bq_addr[$];
  bit          bq_we[$];
  bit          bq_burst[$];
  logic [3:0]  bq_be[$];
  bit          prev_hold = 0;
  logic [31:0] prev_addr;

  // monitor: memory beats, handshake stability, scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req_o && mem_ready) begin
        bq_addr.push_back(mem_addr_o);
        bq_we.push_back(mem_we_o);
        bq_burst.push_back(mem_burst_o);
        bq_be.push_back(mem_be_o);
      end
      if (prev_hold && (!mem_req_o || mem_addr_o != prev_addr)) unstable++;
      prev_hold = mem_req_o && !mem_ready;
      prev_addr = mem_addr_o;
      if (cpu_ready_o) begin
        if (exp_q.size() == 0) check(0, "R11", "unexpected ready", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          if (e.rd) check(cpu_rdata_o == e.data, e.req, "read data", cpu_rdata_o, e.data);
        end
      end
    end
  end

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] be, input string req, output int lat);
    exp_t e;
    e.rd   = !we;
    e.data = we ? 32'h0 : ref_read(a);
    e.req  = req;
    if (we) ref_mem[a[31:2]] = merge(ref_read(a), d, be);
    exp_q.push_back(e);
    bq_addr.delete(); bq_we.delete(); bq_burst.delete(); bq_be.delete();
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_be = be;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!cpu_ready_o && lat < 2000);
    cpu_req = 0;
    @(negedge clk);
    check(!cpu_ready_o, "R11", "ready longer than one cycle", 32'(cpu_ready_o), 0);
  endtask

  function automatic logic [31:0] set_addr(input int tg, input int set);
    return (32'(tg) << 12) | (32'(set) << 4);
  endfunction

  initial begin
    int lat, fifo_diff, pos;
    int resident[$];
    logic [31:0] a_addr, b_addr, u_addr, ev;
    rst_n = 0; cpu_req = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0; cpu_be = 0;
    repeat (3) @(negedge clk);
    check(!cpu_ready_o, "R1", "ready in reset", 32'(cpu_ready_o), 0);
    check(!mem_req_o, "R1", "mem_req in reset", 32'(mem_req_o), 0);
    rst_n = 1;
    @(negedge clk);

    // cold read miss, then hit
    a_addr = 32'h0000_0108;
    access(0, a_addr, 0, 4'hF, "R4", lat);
    check(bq_addr.size() == 4, "R1", "first access beats", bq_addr.size(), 4);
    for (int i = 0; i < 4 && i < bq_addr.size(); i++)
      check(bq_addr[i] == 32'h0000_0100 + 32'(4*i) && bq_burst[i] && !bq_we[i],
            "R4", "fill beat addr", bq_addr[i], 32'h0000_0100 + 32'(4*i));
    access(0, a_addr, 0, 4'hF, "R3", lat);
    check(bq_addr.size() == 0, "R3", "hit beats", bq_addr.size(), 0);
    check(lat == 2, "R3", "hit latency", lat, 2);

    // partial store hit
    access(1, a_addr + 4, 32'hDEAD_BEEF, 4'b0011, "R5", lat);
    check(bq_addr.size() == 0, "R5", "store hit beats", bq_addr.size(), 0);
    access(0, a_addr + 4, 0, 4'hF, "R5", lat);

    // store miss allocates without writing memory
    b_addr = 32'h0000_1204;
    access(1, b_addr, 32'h1234_5678, 4'b1001, "R5", lat);
    check(bq_addr.size() == 4, "R5", "store miss beats", bq_addr.size(), 4);
    foreach (bq_we[i]) check(!bq_we[i], "R5", "write beat on allocate", 32'(bq_we[i]), 0);
    access(0, b_addr, 0, 4'hF, "R5", lat);
    check(bq_addr.size() == 0, "R5", "allocated line hits", bq_addr.size(), 0);

    // four tags coexist in one set, filled into invalid ways
    for (int k = 0; k < 4; k++) begin
      access(0, set_addr(k + 2, 5), 0, 4'hF, "R6", lat);
      check(bq_addr.size() == 4, "R6", "fill of free way", bq_addr.size(), 4);
      foreach (bq_we[i]) check(!bq_we[i], "R6", "eviction before set full", 32'(bq_we[i]), 0);
    end
    for (int k = 0; k < 4; k++) begin
      access(0, set_addr(k + 2, 5), 0, 4'hF, "R2", lat);
      check(bq_addr.size() == 0, "R2", "resident line re-read", bq_addr.size(), 0);
    end

    // dirty lines in a full set: random victims
    for (int k = 0; k < 4; k++) begin
      access(1, set_addr(256 + k, 9), 32'hC0DE_0000 | 32'(k), 4'hF, "R6", lat);
      resident.push_back(256 + k);
    end
    fifo_diff = 0;
    for (int k = 4; k < 16; k++) begin
      access(1, set_addr(256 + k, 9), 32'hC0DE_0000 | 32'(k), 4'hF, "R8", lat);
      check(bq_addr.size() == 8, "R8", "writeback+fill beats", bq_addr.size(), 8);
      if (bq_addr.size() == 8) begin
        ev = {12'h0, bq_addr[0][31:12]};
        for (int i = 0; i < 4; i++) begin
          check(bq_we[i] && bq_burst[i] && bq_be[i] == 4'hF, "R8", "writeback beat kind",
                {bq_we[i], bq_burst[i], bq_be[i]}, 32'h3F);
          check(bq_addr[i] == (set_addr(int'(ev), 9) + 32'(4*i)), "R8", "writeback addr",
                bq_addr[i], set_addr(int'(ev), 9) + 32'(4*i));
          check(!bq_we[i+4], "R8", "refill after writeback", 32'(bq_we[i+4]), 0);
        end
        pos = -1;
        foreach (resident[i]) if (resident[i] == int'(ev)) pos = i;
        check(pos >= 0, "R7", "evicted tag not resident", ev, 0);
        if (pos > 0) fifo_diff++;
        if (pos >= 0) resident.delete(pos);
      end
      resident.push_back(256 + k);
    end
    check(fifo_diff > 0, "R7", "eviction order oldest-first", fifo_diff, 1);
    for (int k = 0; k < 16; k++) access(0, set_addr(256 + k, 9), 0, 4'hF, "R8", lat);

    // uncached region
    u_addr = 32'hF000_0010;
    access(1, u_addr, 32'h1122_3344, 4'b0100, "R9", lat);
    check(bq_addr.size() == 1, "R9", "uncached store beats", bq_addr.size(), 1);
    if (bq_addr.size() == 1)
      check(bq_we[0] && !bq_burst[0] && bq_be[0] == 4'b0100 && bq_addr[0] == u_addr,
            "R9", "uncached store beat", bq_addr[0], u_addr);
    access(0, u_addr, 0, 4'hF, "R9", lat);
    check(bq_addr.size() == 1 && !bq_we[0], "R9", "uncached read beats", bq_addr.size(), 1);
    access(0, u_addr, 0, 4'hF, "R9", lat);
    check(bq_addr.size() == 1, "R9", "uncached read allocated", bq_addr.size(), 1);
    access(0, a_addr, 0, 4'hF, "R9", lat);
    check(bq_addr.size() == 0, "R9", "cached line lost", bq_addr.size(), 0);

    check(unstable == 0, "R10", "request changed while waiting", unstable, 0);
    check(exp_q.size() == 0, "R11", "responses missing", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule